// File: doc/BRIEF.md
# Channel Controller Host Register Interface

This block sits between a host processor's I/O bus and a mass-storage channel controller. The host issues four kinds of single-cycle operation: status read, control write, data read and data write. A data write names a target register in its upper bits. The block keeps a small set of controller-local registers, which are the command/start register, the interrupt-vector register and the per-drive access-error register. A data write to any register number from 000 to 037 is passed to the selected drive through a simple drive-register port.

A valid command load starts the data channel. The block pulses a start strobe and hands over a control-word address. It also passes the low function bits to the drive's control register. The DMA channel itself lies outside this block. It appears here only as that strobe, a busy input, its initial-address value and three error-event inputs. The status word holds the priority level, the interrupt enables and five sticky flags. An interrupt request output is a level that stays high while an enabled cause is pending.

Top module: `chan_host_regif`

## Requirements
- R1: After reset the status word reads zero, irq is low, the access-error register reads zero and the latched register and drive selectors are zero.
- R2: Every data write latches bits 35..30 as the register selector. The drive selector latches bits 20..18 on a valid command start, on any write to registers 000–037 with load (bit 29) set, and on non-load writes to registers 000–037 other than 004.
- R3: A load of register 040 while chan_busy is high sets the channel-active flag (status bit 9) and starts nothing.
- R4: A load of register 040 with the go bit (bit 0) clear has no effect: no start and no drive write.
- R5: A load of register 040 with go set and function code (bits 5..1) below octal 24 sets the illegal-function flag (status bit 8) and starts nothing.
- R6: A valid command load pulses chan_start in the same cycle, with chan_cw_addr equal to the data word shifted right by 6. It also writes the low 6 bits to drive register 0 of the drive in bits 20..18.
- R7: Register 044 loads a 7-bit vector from bits 6..0 and a mode bit from bit 19. A read returns the vector with bit 19 set when the mode is 1 and bit 18 set when the mode is 0.
- R8: Register 054 holds one access-error bit per drive, set by aerr_set. A load clears the bits where bits 7..0 are one, and the access-error interrupt cause goes away once all bits are zero.
- R9: A load of registers 000–037 produces a drive write of bits 17..0 to that register number, unless the addressed drive's access-error bit is set, in which case no write occurs.
- R10: Data reads carry the register selector in bits 35..30. For drive registers the result holds the 16 drive data bits and the drive number in bits 20..18. Register 040 returns the drive control low 6 bits, chan_cia in bits 17..6 and the drive number in bits 20..18.
- R11: A status read returns priority in bits 2..0, the attention enable in bit 5 only while attn_in is high, the access-error enable in bit 6 only while any access-error bit is set, and flags overrun/illegal/channel-active/channel-error/drive-exception in bits 7..11.
- R12: A control write loads the priority from bits 2..0, the attention enable from bit 5 and the access-error enable from bit 6. Ones in bits 7..11 clear the matching flags.
- R13: irq is high exactly when the priority is non-zero and at least one cause is pending: the illegal-function flag, an enabled attention, or an enabled access error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_valid | input | 1 | Host operation present this cycle |
| host_op | input | 2 | 0 status read, 1 control write, 2 data read, 3 data write |
| host_wdata | input | 36 | Host write word |
| host_rdata | output | 36 | Read result, valid in the cycle of a read |
| irq | output | 1 | Interrupt request level |
| chan_busy | input | 1 | Data channel busy |
| chan_cia | input | 12 | Channel initial address, reported on register 040 reads |
| chan_start | output | 1 | Channel start strobe |
| chan_cw_addr | output | 30 | Control-word address given with the start |
| ovr_set | input | 1 | Sets the overrun flag |
| cerr_set | input | 1 | Sets the channel-error flag |
| dexc_set | input | 1 | Sets the drive-exception flag |
| attn_in | input | 1 | Some drive has attention pending |
| aerr_set | input | NDRV | Sets access-error bits per drive |
| drv_wr | output | 1 | Drive register write strobe |
| drv_rd | output | 1 | Drive register read strobe |
| drv_unit | output | 3 | Drive addressed on the drive port |
| drv_addr | output | 5 | Drive register number |
| drv_wdata | output | 18 | Drive write data |
| drv_rdata | input | 16 | Drive read data |

## Verification
The bench checks the gating of command loads. A busy load, a load with go clear and a low function code must each start nothing. A design that checked the function before busy or go would raise the illegal flag or pulse a start when it should not. The bench also checks that a non-load write to register 004 keeps the old drive selector, because a design that latched it would then read data from the wrong drive. It checks that a drive write is dropped only for the drive whose access-error bit is set, and that the enable bits in the status word are masked by their conditions. A design without the masking would report enables as pending interrupts.

// File: rtl/hri_pkg.sv
// Package: shared op codes, register numbers and field positions for the
// channel controller host register interface.
package hri_pkg;
    localparam int WORD_W  = 36;
    localparam int REG_W   = 6;
    localparam int FN_W    = 5;
    localparam int PRI_W   = 3;
    localparam int FLAG_N  = 5;
    localparam int STAT_W  = 12;

    typedef enum logic [1:0] {
        OP_STAT_RD = 2'd0,
        OP_CTL_WR  = 2'd1,
        OP_DAT_RD  = 2'd2,
        OP_DAT_WR  = 2'd3
    } host_op_e;

    // controller-local register numbers
    localparam logic [REG_W-1:0] REG_CMD  = 6'o40;
    localparam logic [REG_W-1:0] REG_VEC  = 6'o44;
    localparam logic [REG_W-1:0] REG_AERR = 6'o54;
    localparam logic [REG_W-1:0] REG_ASUM = 6'o04;
    localparam logic [FN_W-1:0]  FN_FIRST_XFER = 5'o24;

    // host word field positions
    localparam int W_REG_LSB = 30;
    localparam int W_LOAD    = 29;
    localparam int W_DRV_LSB = 18;
    localparam int W_MODE    = 19;
    localparam int W_MODE0   = 18;

    // status word positions
    localparam int ST_ATTN_EN = 5;
    localparam int ST_AERR_EN = 6;
    localparam int ST_FLAG_LSB = 7;
    // flag indices inside the flag vector
    localparam int FL_OVR  = 0;
    localparam int FL_ILF  = 1;
    localparam int FL_CACT = 2;
    localparam int FL_CERR = 3;
    localparam int FL_DEXC = 4;
endpackage

// File: rtl/hri_wr_decode.sv
// Module: hri_wr_decode
// Combinational decode of a host data write into command, vector,
// access-error and drive-forward actions. Assumes one op per cycle.
module hri_wr_decode
    import hri_pkg::*;
#(
    parameter int NDRV  = 8,
    parameter int DRV_W = $clog2(NDRV)
) (
    input  logic             is_dwr,
    input  logic             load,
    input  logic [REG_W-1:0] wr_reg,
    input  logic [DRV_W-1:0] wr_drv,
    input  logic [FN_W-1:0]  wr_fn,
    input  logic             wr_go,
    input  logic [7:0]       wr_low8,
    input  logic             chan_busy,
    input  logic [NDRV-1:0]  aerr_q,
    output logic             cmd_busy,
    output logic             cmd_illegal,
    output logic             cmd_start,
    output logic             vec_ld,
    output logic [NDRV-1:0]  aerr_clr,
    output logic             drv_fwd,
    output logic             drv_latch
);
    logic cmd_sel;
    logic drv_reg;

    // classify the write by target register
    always_comb begin
        cmd_sel     = is_dwr && load && (wr_reg == REG_CMD);
        drv_reg     = !wr_reg[REG_W-1];
        cmd_busy    = cmd_sel && chan_busy;
        cmd_illegal = cmd_sel && !chan_busy && wr_go && (wr_fn < FN_FIRST_XFER);
        cmd_start   = cmd_sel && !chan_busy && wr_go && (wr_fn >= FN_FIRST_XFER);
        vec_ld      = is_dwr && load && (wr_reg == REG_VEC);
        aerr_clr    = (is_dwr && load && (wr_reg == REG_AERR)) ? wr_low8[NDRV-1:0] : '0;
        drv_fwd     = is_dwr && load && drv_reg && !aerr_q[wr_drv];
        drv_latch   = cmd_start || (is_dwr && drv_reg && (load || (wr_reg != REG_ASUM)));
    end
endmodule

// File: rtl/hri_local_regs.sv
// Module: hri_local_regs
// Holds the register and drive selectors, the interrupt vector and mode,
// and the per-drive access-error bits. Set requests beat clear requests.
module hri_local_regs
    import hri_pkg::*;
#(
    parameter int NDRV  = 8,
    parameter int DRV_W = $clog2(NDRV),
    parameter int VEC_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             is_dwr,
    input  logic [REG_W-1:0] wr_reg,
    input  logic             drv_latch,
    input  logic [DRV_W-1:0] wr_drv,
    input  logic             vec_ld,
    input  logic [VEC_W-1:0] vec_wdata,
    input  logic             mode_wdata,
    input  logic [NDRV-1:0]  aerr_clr,
    input  logic [NDRV-1:0]  aerr_set,
    output logic [REG_W-1:0] reg_q,
    output logic [DRV_W-1:0] drv_q,
    output logic [VEC_W-1:0] vec_q,
    output logic             mode_q,
    output logic [NDRV-1:0]  aerr_q
);
    // selector latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q <= '0;
            drv_q <= '0;
        end else begin
            if (is_dwr)    reg_q <= wr_reg;
            if (drv_latch) drv_q <= wr_drv;
        end
    end

    // interrupt vector and mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q  <= '0;
            mode_q <= 1'b0;
        end else if (vec_ld) begin
            vec_q  <= vec_wdata;
            mode_q <= mode_wdata;
        end
    end

    // per-drive access-error bits, one slice per drive
    for (genvar d = 0; d < NDRV; d++) begin : g_aerr
        always_ff @(posedge clk) begin
            if (!rst_n)           aerr_q[d] <= 1'b0;
            else if (aerr_set[d]) aerr_q[d] <= 1'b1;
            else if (aerr_clr[d]) aerr_q[d] <= 1'b0;
        end
    end

    a_r8_clear_by_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (|(aerr_clr & ~aerr_set)) |=> ((aerr_q & $past(aerr_clr & ~aerr_set)) == '0));
    a_r7_vec_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_ld |=> $stable(vec_q) && $stable(mode_q));
endmodule

// File: rtl/hri_ctl_status.sv
// Module: hri_ctl_status
// Status word: priority, two interrupt enables and five sticky flags,
// plus the level interrupt request. A set event beats a clear in a cycle.
module hri_ctl_status
    import hri_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [PRI_W-1:0]  pri_wdata,
    input  logic              attn_en_wdata,
    input  logic              aerr_en_wdata,
    input  logic [FLAG_N-1:0] flag_clr,
    input  logic              cmd_busy,
    input  logic              cmd_illegal,
    input  logic              ovr_set,
    input  logic              cerr_set,
    input  logic              dexc_set,
    input  logic              attn_in,
    input  logic              aerr_any,
    output logic [STAT_W-1:0] status,
    output logic              irq
);
    logic [PRI_W-1:0]  pri_q;
    logic              attn_en_q;
    logic              aerr_en_q;
    logic [FLAG_N-1:0] flags_q;
    logic [FLAG_N-1:0] flag_set;

    // gather the flag set events
    always_comb begin
        flag_set          = '0;
        flag_set[FL_OVR]  = ovr_set;
        flag_set[FL_ILF]  = cmd_illegal;
        flag_set[FL_CACT] = cmd_busy;
        flag_set[FL_CERR] = cerr_set;
        flag_set[FL_DEXC] = dexc_set;
    end

    // priority and enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pri_q     <= '0;
            attn_en_q <= 1'b0;
            aerr_en_q <= 1'b0;
        end else if (ctl_wr) begin
            pri_q     <= pri_wdata;
            attn_en_q <= attn_en_wdata;
            aerr_en_q <= aerr_en_wdata;
        end
    end

    // sticky flags
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~(ctl_wr ? flag_clr : '0)) | flag_set;
    end

    // status word and interrupt level
    always_comb begin
        status = '0;
        status[PRI_W-1:0] = pri_q;
        status[ST_ATTN_EN] = attn_en_q && attn_in;
        status[ST_AERR_EN] = aerr_en_q && aerr_any;
        status[ST_FLAG_LSB +: FLAG_N] = flags_q;
        irq = (pri_q != '0) &&
              (flags_q[FL_ILF] || (attn_en_q && attn_in) || (aerr_en_q && aerr_any));
    end

    a_r5_ilf_sets: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_illegal |=> status[ST_FLAG_LSB + FL_ILF]);
    a_r3_busy_sets_active: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_busy |=> status[ST_FLAG_LSB + FL_CACT]);
    a_r12_ilf_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && flag_clr[FL_ILF] && !cmd_illegal) |=> !status[ST_FLAG_LSB + FL_ILF]);
endmodule

// File: rtl/hri_rd_mux.sv
// Module: hri_rd_mux
// Builds the host read word for status and data reads from held state
// and the drive read port. Purely combinational.
module hri_rd_mux
    import hri_pkg::*;
#(
    parameter int NDRV  = 8,
    parameter int DRV_W = $clog2(NDRV),
    parameter int VEC_W = 7,
    parameter int CIA_W = 12
) (
    input  logic              rd_valid,
    input  host_op_e          op,
    input  logic [STAT_W-1:0] status,
    input  logic [REG_W-1:0]  reg_q,
    input  logic [DRV_W-1:0]  drv_q,
    input  logic [VEC_W-1:0]  vec_q,
    input  logic              mode_q,
    input  logic [NDRV-1:0]   aerr_q,
    input  logic [15:0]       drv_rdata,
    input  logic [CIA_W-1:0]  cia,
    output logic [WORD_W-1:0] rdata
);
    // select the read source by op and register selector
    always_comb begin
        rdata = '0;
        if (rd_valid) begin
            case (op)
                OP_STAT_RD: rdata[STAT_W-1:0] = status;
                OP_DAT_RD: begin
                    if (reg_q == REG_CMD) begin
                        rdata[5:0]              = drv_rdata[5:0];
                        rdata[6 +: CIA_W]       = cia;
                        rdata[W_DRV_LSB +: DRV_W] = drv_q;
                    end else if (reg_q == REG_VEC) begin
                        rdata[VEC_W-1:0] = vec_q;
                        rdata[W_MODE]    = mode_q;
                        rdata[W_MODE0]   = !mode_q;
                    end else if (reg_q == REG_AERR) begin
                        rdata[NDRV-1:0] = aerr_q;
                    end else if (!reg_q[REG_W-1]) begin
                        rdata[15:0]               = drv_rdata;
                        rdata[W_DRV_LSB +: DRV_W] = drv_q;
                    end
                    rdata[W_REG_LSB +: REG_W] = reg_q;
                end
                default: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/chan_host_regif.sv
// Module: chan_host_regif
// Top of the host register interface. Every host op completes in the cycle
// it is presented; read data is combinational from held state and the
// drive port. Assumes NDRV <= 8 so the drive field fits bits 20..18.
module chan_host_regif
    import hri_pkg::*;
#(
    parameter int NDRV  = 8,
    parameter int VEC_W = 7,
    parameter int CIA_W = 12,
    localparam int DRV_W = $clog2(NDRV)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_valid,
    input  logic [1:0]        host_op,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    output logic              irq,
    input  logic              chan_busy,
    input  logic [CIA_W-1:0]  chan_cia,
    output logic              chan_start,
    output logic [WORD_W-7:0] chan_cw_addr,
    input  logic              ovr_set,
    input  logic              cerr_set,
    input  logic              dexc_set,
    input  logic              attn_in,
    input  logic [NDRV-1:0]   aerr_set,
    output logic              drv_wr,
    output logic              drv_rd,
    output logic [2:0]        drv_unit,
    output logic [4:0]        drv_addr,
    output logic [17:0]       drv_wdata,
    input  logic [15:0]       drv_rdata
);
    host_op_e          op;
    logic              is_dwr, is_cwr;
    logic [REG_W-1:0]  wr_reg;
    logic [DRV_W-1:0]  wr_drv;
    logic              cmd_busy, cmd_illegal, cmd_start, vec_ld, drv_fwd, drv_latch;
    logic [NDRV-1:0]   aerr_clr, aerr_q;
    logic [REG_W-1:0]  reg_q;
    logic [DRV_W-1:0]  drv_q;
    logic [VEC_W-1:0]  vec_q;
    logic              mode_q;
    logic [STAT_W-1:0] status;

    // operation qualifiers and write fields
    always_comb begin
        op     = host_op_e'(host_op);
        is_dwr = host_valid && (op == OP_DAT_WR);
        is_cwr = host_valid && (op == OP_CTL_WR);
        wr_reg = host_wdata[W_REG_LSB +: REG_W];
        wr_drv = host_wdata[W_DRV_LSB +: DRV_W];
    end

    hri_wr_decode #(.NDRV(NDRV), .DRV_W(DRV_W)) u_dec (
        .is_dwr     (is_dwr),
        .load       (host_wdata[W_LOAD]),
        .wr_reg     (wr_reg),
        .wr_drv     (wr_drv),
        .wr_fn      (host_wdata[5:1]),
        .wr_go      (host_wdata[0]),
        .wr_low8    (host_wdata[7:0]),
        .chan_busy  (chan_busy),
        .aerr_q     (aerr_q),
        .cmd_busy   (cmd_busy),
        .cmd_illegal(cmd_illegal),
        .cmd_start  (cmd_start),
        .vec_ld     (vec_ld),
        .aerr_clr   (aerr_clr),
        .drv_fwd    (drv_fwd),
        .drv_latch  (drv_latch)
    );

    hri_local_regs #(.NDRV(NDRV), .DRV_W(DRV_W), .VEC_W(VEC_W)) u_loc (
        .clk       (clk),
        .rst_n     (rst_n),
        .is_dwr    (is_dwr),
        .wr_reg    (wr_reg),
        .drv_latch (drv_latch),
        .wr_drv    (wr_drv),
        .vec_ld    (vec_ld),
        .vec_wdata (host_wdata[VEC_W-1:0]),
        .mode_wdata(host_wdata[W_MODE]),
        .aerr_clr  (aerr_clr),
        .aerr_set  (aerr_set),
        .reg_q     (reg_q),
        .drv_q     (drv_q),
        .vec_q     (vec_q),
        .mode_q    (mode_q),
        .aerr_q    (aerr_q)
    );

    hri_ctl_status u_stat (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl_wr       (is_cwr),
        .pri_wdata    (host_wdata[PRI_W-1:0]),
        .attn_en_wdata(host_wdata[ST_ATTN_EN]),
        .aerr_en_wdata(host_wdata[ST_AERR_EN]),
        .flag_clr     (host_wdata[ST_FLAG_LSB +: FLAG_N]),
        .cmd_busy     (cmd_busy),
        .cmd_illegal  (cmd_illegal),
        .ovr_set      (ovr_set),
        .cerr_set     (cerr_set),
        .dexc_set     (dexc_set),
        .attn_in      (attn_in),
        .aerr_any     (|aerr_q),
        .status       (status),
        .irq          (irq)
    );

    hri_rd_mux #(.NDRV(NDRV), .DRV_W(DRV_W), .VEC_W(VEC_W), .CIA_W(CIA_W)) u_rd (
        .rd_valid (host_valid),
        .op       (op),
        .status   (status),
        .reg_q    (reg_q),
        .drv_q    (drv_q),
        .vec_q    (vec_q),
        .mode_q   (mode_q),
        .aerr_q   (aerr_q),
        .drv_rdata(drv_rdata),
        .cia      (chan_cia),
        .rdata    (host_rdata)
    );

    // channel start and drive port
    always_comb begin
        chan_start   = cmd_start;
        chan_cw_addr = host_wdata[WORD_W-1:6];
        drv_wr       = cmd_start || drv_fwd;
        drv_rd       = host_valid && (op == OP_DAT_RD) &&
                       (!reg_q[REG_W-1] || (reg_q == REG_CMD));
        drv_unit     = '0;
        drv_addr     = '0;
        drv_wdata    = '0;
        if (is_dwr) begin
            drv_unit[DRV_W-1:0] = wr_drv;
            drv_addr  = cmd_start ? 5'd0 : wr_reg[4:0];
            drv_wdata = cmd_start ? {12'd0, host_wdata[5:0]} : host_wdata[17:0];
        end else begin
            drv_unit[DRV_W-1:0] = drv_q;
            drv_addr  = reg_q[REG_W-1] ? 5'd0 : reg_q[4:0];
        end
    end

    a_r6_start_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        chan_start |-> !chan_busy && drv_wr && (drv_addr == 5'd0));
    a_r4_go_clear_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (is_dwr && host_wdata[W_LOAD] && (wr_reg == REG_CMD) && !host_wdata[0])
        |-> !chan_start && !drv_wr);
    a_r9_aerr_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        (is_dwr && host_wdata[W_LOAD] && !wr_reg[REG_W-1] && aerr_q[wr_drv]) |-> !drv_wr);
    a_r13_irq_needs_pri: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status[PRI_W-1:0] != '0));
endmodule

// File: tb/sim_chan_host_regif.sv
module sim_chan_host_regif;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_valid = 1'b0;
    logic [1:0]  host_op = 2'd0;
    logic [35:0] host_wdata = '0;
    logic [35:0] host_rdata;
    logic        irq;
    logic        chan_busy = 1'b0;
    logic [11:0] chan_cia = 12'o4321;
    logic        chan_start;
    logic [29:0] chan_cw_addr;
    logic        ovr_set = 1'b0, cerr_set = 1'b0, dexc_set = 1'b0, attn_in = 1'b0;
    logic [7:0]  aerr_set = '0;
    logic        drv_wr, drv_rd;
    logic [2:0]  drv_unit;
    logic [4:0]  drv_addr;
    logic [17:0] drv_wdata;
    logic [15:0] drv_rdata;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    localparam logic [1:0] SR = 2'd0, CW = 2'd1, DR = 2'd2, DW = 2'd3;

    // drive-port model: marker, unit and register number
    assign drv_rdata = {5'b10000, drv_unit, 3'b000, drv_addr};

    always #2 clk = ~clk;

    chan_host_regif u0 (
        .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_op(host_op),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq),
        .chan_busy(chan_busy), .chan_cia(chan_cia), .chan_start(chan_start),
        .chan_cw_addr(chan_cw_addr), .ovr_set(ovr_set), .cerr_set(cerr_set),
        .dexc_set(dexc_set), .attn_in(attn_in), .aerr_set(aerr_set),
        .drv_wr(drv_wr), .drv_rd(drv_rd), .drv_unit(drv_unit), .drv_addr(drv_addr),
        .drv_wdata(drv_wdata), .drv_rdata(drv_rdata)
    );

    // {op, busy, check, wdata, expected read}
    localparam int NV = 20;
    localparam logic [75:0] TBL [NV] = '{
        {DW, 1'b0, 1'b0, 36'o444002000123, 36'o0},
        {DR, 1'b0, 1'b1, 36'o0, 36'o440002000123},
        {DW, 1'b0, 1'b0, 36'o444000000077, 36'o0},
        {DR, 1'b0, 1'b1, 36'o0, 36'o440001000077},
        {DW, 1'b0, 1'b0, 36'o054003001234, 36'o0},
        {DR, 1'b0, 1'b1, 36'o0, 36'o050003101405},
        {DW, 1'b0, 1'b0, 36'o120006000000, 36'o0},
        {DR, 1'b0, 1'b1, 36'o0, 36'o120006103012},
        {DW, 1'b0, 1'b0, 36'o040002000000, 36'o0},
        {DR, 1'b0, 1'b1, 36'o0, 36'o040006103004},
        {DW, 1'b0, 1'b0, 36'o404005000071, 36'o0},
        {DR, 1'b0, 1'b1, 36'o0, 36'o400005432100},
        {DW, 1'b0, 1'b0, 36'o404000000021, 36'o0},
        {SR, 1'b0, 1'b1, 36'o0, 36'o400},
        {CW, 1'b0, 1'b0, 36'o445, 36'o0},
        {SR, 1'b0, 1'b1, 36'o0, 36'o5},
        {DW, 1'b1, 1'b0, 36'o404000000071, 36'o0},
        {SR, 1'b0, 1'b1, 36'o0, 36'o1005},
        {DW, 1'b0, 1'b0, 36'o404000000070, 36'o0},
        {SR, 1'b0, 1'b1, 36'o0, 36'o1005}
    };

    task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%o expected=%o", tag, act, exp);
        end
    endtask

    // present an op at the falling edge; outputs settle 1 ns later
    task automatic put(input logic [1:0] o, input logic [35:0] w);
        @(negedge clk);
        host_valid = 1'b1;
        host_op    = o;
        host_wdata = w;
        #1;
    endtask

    // commit the op at the rising edge, then idle
    task automatic commit();
        @(posedge clk);
        #1;
        host_valid = 1'b0;
        chan_busy  = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();

        // vector table: latching, vector reg, reads, command gating, status
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            chan_busy = TBL[i][73];
            put(TBL[i][75:74], TBL[i][71:36]);
            if (TBL[i][72])
                chk($sformatf("table step %0d (R2 R3 R4 R5 R7 R10 R11 R12)", i),
                    host_rdata, TBL[i][35:0]);
            commit();
        end

        // R1 reset state
        do_reset();
        put(SR, '0);
        chk("R1 status after reset", host_rdata, 36'o0);
        chk("R1 irq after reset", {35'd0, irq}, 36'o0);
        commit();
        put(DR, '0);
        chk("R1 selectors zero after reset", host_rdata, 36'o000000100000);
        commit();
        put(DW, 36'o540000000000);
        commit();
        put(DR, '0);
        chk("R1 access-error reg zero", host_rdata, 36'o540000000000);
        commit();

        // R6 valid start
        put(DW, 36'o404007123471);
        chk("R6 start strobe", {35'd0, chan_start}, 36'd1);
        chk("R6 control-word address", {6'd0, chan_cw_addr}, 36'o004040071234);
        chk("R6 drive write strobe", {35'd0, drv_wr}, 36'd1);
        chk("R6 drive write target", {28'd0, drv_unit, drv_addr}, {28'd0, 3'd7, 5'd0});
        chk("R6 drive write data", {18'd0, drv_wdata}, 36'o71);
        commit();

        // R5 illegal function starts nothing; R13 priority gates irq
        put(DW, 36'o404000000047);
        chk("R5 no start on low function", {34'd0, chan_start, drv_wr}, 36'd0);
        commit();
        put(SR, '0);
        chk("R13 irq low at priority 0", {35'd0, irq}, 36'd0);
        commit();
        put(CW, 36'o7);
        commit();
        put(SR, '0);
        chk("R13 irq with illegal flag", {35'd0, irq}, 36'd1);
        commit();
        put(CW, 36'o407);
        commit();
        put(SR, '0);
        chk("R12 illegal flag cleared", host_rdata, 36'o7);
        chk("R13 irq drops after clear", {35'd0, irq}, 36'd0);
        commit();

        // R8 / R9 access errors
        @(negedge clk); aerr_set = 8'h08;
        @(posedge clk); #1; aerr_set = '0;
        put(CW, 36'o107);
        commit();
        put(SR, '0);
        chk("R11 access-error enable shown", host_rdata, 36'o107);
        chk("R13 irq on access error", {35'd0, irq}, 36'd1);
        commit();
        put(DW, 36'o054003000777);
        chk("R9 write to errored drive dropped", {35'd0, drv_wr}, 36'd0);
        commit();
        put(DW, 36'o054002000777);
        chk("R9 write to clean drive forwarded", {35'd0, drv_wr}, 36'd1);
        chk("R9 forwarded target", {28'd0, drv_unit, drv_addr}, {28'd0, 3'd2, 5'd5});
        chk("R9 forwarded data", {18'd0, drv_wdata}, 36'o777);
        commit();
        put(DW, 36'o540000000000);
        commit();
        put(DR, '0);
        chk("R8 access-error bit readable", host_rdata, 36'o540000000010);
        commit();
        put(DW, 36'o544000000010);
        commit();
        put(SR, '0);
        chk("R8 bit cleared, enable masked", host_rdata, 36'o7);
        chk("R8 irq withdrawn", {35'd0, irq}, 36'd0);
        commit();

        // R11 attention gating
        put(CW, 36'o047);
        commit();
        put(SR, '0);
        chk("R11 attention enable hidden", host_rdata, 36'o7);
        commit();
        @(negedge clk); attn_in = 1'b1;
        put(SR, '0);
        chk("R11 attention enable shown", host_rdata, 36'o47);
        chk("R13 irq on attention", {35'd0, irq}, 36'd1);
        commit();
        @(negedge clk); attn_in = 1'b0;

        // R12 flag set and selective clear
        @(negedge clk); ovr_set = 1'b1; cerr_set = 1'b1; dexc_set = 1'b1;
        @(posedge clk); #1; ovr_set = 1'b0; cerr_set = 1'b0; dexc_set = 1'b0;
        put(SR, '0);
        chk("R11 event flags reported", host_rdata, 36'o6207);
        commit();
        put(CW, 36'o2207);
        commit();
        put(SR, '0);
        chk("R12 selective flag clear", host_rdata, 36'o4007);
        commit();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule